// File: doc/BRIEF.md
# Loop-Replay Issue Queue Array

This block is the storage side of an issue queue that can hold a captured loop. It keeps the loop's instructions resident after they issue and re-dispatches them without the fetch and decode stages. Each entry stores an instruction tag, three logical register numbers, three renamed register fields, a sequence number, a pinned ("classification") bit and an issued-state bit. During normal operation an entry leaves the queue when it issues. An entry that was written while a loop was being captured is pinned instead. When it issues, it stays in place and only its issued-state bit is set.

When capture ends, the block enters replay mode and raises a gate output that holds the front end idle. While the gate is high, branches run under static prediction and are still verified at completion. A replay pointer walks the captured range in program order, N entries per cycle. It sends their logical registers to an external renamer once every entry in the window has issued. It wraps from the last captured entry back to the first. The renamer's physical tags are written back into the same entries. Two cleanup sequences return the queue to normal operation: a revoke, and a misprediction recovery, which also flushes younger work. Wakeup, select, the reorder buffer and the renamer are outside the block and appear only as ports.

Top module: `loop_replay_iq`

## Requirements
- R1: After reset, no entry is valid, the write slot is entry 0, `allocReady` is 1, `frontGate` is 0 and `renValid` is 0.
- R2: An entry written while capture is active (after `bufStart`, before `bufEnd`) is valid with its pinned bit 1 and issued bit 0, and it holds the given tag. Logical registers are packed as {dst, srcB, srcA} with srcA in the low field. Entries are written at a slot that advances by one per write.
- R3: Issuing a pinned entry keeps it valid and sets its issued bit. Issuing an unpinned entry frees it.
- R4: In replay mode the window is the N entries from the pointer, cut off after the last captured entry. If any entry in the window has its issued bit clear, `renValid` is 0 and the pointer holds.
- R5: When every entry in the window has issued, `renValid` is 1. `renIdx` is the pointer, and `renMask` bit k marks lane k in use. Lane k of `renLregs` holds entry `renIdx+k`'s logical registers. At the next edge the sent entries' issued bits clear and the pointer moves forward by N.
- R6: After a send that reaches the last captured entry, the pointer returns to the first captured entry.
- R7: A rename return writes `retPhys` lane k (packed {pdst, psrcB, psrcA}) into entry `retIdx+k` for each set bit of `retMask`.
- R8: On `revoke`, every entry that is both pinned and issued is freed, all other entries lose their pinned bit, and the block returns to normal mode with `frontGate` low.
- R9: On `mispredict`, the revoke cleanup is applied. In addition, every entry whose sequence number is younger than `mispredSeq` (modular difference nonzero with clear sign bit) is freed, and the write slot becomes `mispredIdx+1`.
- R10: In replay mode, `frontGate` is 1 and `allocReady` is 0, so an allocation request writes no entry. A `bufEnd` with no captured entry returns to normal mode without raising `frontGate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Write request for a new instruction |
| allocTag | input | TAG_W | Instruction tag |
| allocLregs | input | 3*LREG_W | Logical registers {dst, srcB, srcA} |
| allocPhys | input | 3*PREG_W | Renamed registers {pdst, psrcB, psrcA} |
| allocSeq | input | SEQ_W | Program-order sequence number |
| allocReady | output | 1 | Write slot free and not in replay |
| bufStart | input | 1 | Begin capturing a loop |
| bufEnd | input | 1 | End capture and enter replay |
| issueValid | input | 1 | An entry was issued |
| issueIdx | input | IDX_W | Index of the issued entry |
| renValid | output | 1 | Replay window sent to the renamer |
| renIdx | output | IDX_W | First entry of the window |
| renMask | output | LANES | Lanes in use |
| renLregs | output | LANES*3*LREG_W | Logical registers per lane |
| retValid | input | 1 | Renamer result valid |
| retIdx | input | IDX_W | First entry of the result |
| retMask | input | LANES | Lanes carrying results |
| retPhys | input | LANES*3*PREG_W | Physical tags per lane |
| revoke | input | 1 | Abandon capture or replay |
| mispredict | input | 1 | Branch misprediction recovery |
| mispredIdx | input | IDX_W | Entry of the mispredicted branch |
| mispredSeq | input | SEQ_W | Sequence number of that branch |
| frontGate | output | 1 | Front end gated, static prediction in force |
| rdIdx | input | IDX_W | Inspection read index |
| rdValid | output | 1 | Entry valid |
| rdClass | output | 1 | Entry pinned |
| rdIssued | output | 1 | Entry issued bit |
| rdTag | output | TAG_W | Entry tag |
| rdLregs | output | 3*LREG_W | Entry logical registers |
| rdPhys | output | 3*PREG_W | Entry physical registers |

## Verification
The replay scan is driven with windows where only some entries have issued, and with windows where all have. The first kind shows that a partial window stalls and the second that a complete one sends. A three-entry loop with two lanes produces a full window followed by a one-lane tail, which separates correct clipping at the last entry and correct wrapping from a pointer that always steps by N. The two cleanup paths are run against entries in every mix of pinned, issued and age. In that mix, a sent-but-unissued younger entry survives a revoke but is freed by a misprediction, and an older unpinned entry survives both.

// File: rtl/lriq_pkg.sv
package lriq_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_BUFFER = 2'd1,
    MODE_REUSE  = 2'd2
  } lriqMode_e;

  typedef struct packed {
    logic allocEn;
    logic allocClass;
    logic sendEn;
    logic cleanEn;
    logic flushEn;
  } lriqStrobe_t;

endpackage

// File: rtl/lriq_ctrl.sv
module lriq_ctrl
  import lriq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             bufStart,
  input  logic             bufEnd,
  input  logic             revoke,
  input  logic             mispredict,
  input  logic [IDX_W-1:0] mispredIdx,
  input  logic [DEPTH-1:0] validVec,
  input  logic [DEPTH-1:0] issuedVec,
  output lriqStrobe_t      strb,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] ptr,
  output logic [LANES-1:0] sendMask,
  output logic             allocReady,
  output logic             frontGate
);

  lriqMode_e        mode;
  logic [IDX_W-1:0] first;
  logic [IDX_W-1:0] last;
  logic [IDX_W:0]   bufCount;
  logic [IDX_W:0]   remain;
  logic             winReady;
  logic             allocFire;
  logic             sendFire;
  logic             anyClean;

  assign anyClean   = revoke | mispredict;
  assign frontGate  = (mode == MODE_REUSE);
  assign allocReady = (mode != MODE_REUSE) && !validVec[tail];
  assign allocFire  = allocValid && allocReady && !anyClean;

  // distance from pointer to the last captured entry, inclusive
  assign remain = {1'b0, IDX_W'(last - ptr)} + (IDX_W+1)'(1);

  always_comb begin
    winReady = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      sendMask[k] = ((IDX_W+1)'(k) < remain);
      if (sendMask[k] && !issuedVec[IDX_W'(ptr + IDX_W'(k))]) winReady = 1'b0;
    end
  end

  assign sendFire = frontGate && winReady && !anyClean;

  always_comb begin
    strb            = '0;
    strb.allocEn    = allocFire;
    strb.allocClass = (mode == MODE_BUFFER);
    strb.sendEn     = sendFire;
    strb.cleanEn    = anyClean;
    strb.flushEn    = mispredict;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_NORMAL;
      tail     <= '0;
      ptr      <= '0;
      first    <= '0;
      last     <= '0;
      bufCount <= '0;
    end else if (mispredict) begin
      mode <= MODE_NORMAL;
      tail <= mispredIdx + IDX_W'(1);
    end else if (revoke) begin
      mode <= MODE_NORMAL;
    end else begin
      if (allocFire) tail <= tail + IDX_W'(1);
      unique case (mode)
        MODE_NORMAL: begin
          if (bufStart) begin
            mode     <= MODE_BUFFER;
            first    <= allocFire ? tail + IDX_W'(1) : tail;
            bufCount <= '0;
          end
        end
        MODE_BUFFER: begin
          if (allocFire) begin
            last     <= tail;
            bufCount <= bufCount + (IDX_W+1)'(1);
          end
          if (bufEnd) begin
            mode <= (bufCount != '0 || allocFire) ? MODE_REUSE : MODE_NORMAL;
            ptr  <= first;
          end
        end
        MODE_REUSE: begin
          if (sendFire) begin
            if (remain <= (IDX_W+1)'(LANES)) ptr <= first;
            else                             ptr <= ptr + IDX_W'(LANES);
          end
        end
        default: mode <= MODE_NORMAL;
      endcase
    end
  end

endmodule

// File: rtl/lriq_array.sv
module lriq_array
  import lriq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LANES  = 2,
  parameter int TAG_W  = 8,
  parameter int LREG_W = 5,
  parameter int PREG_W = 6,
  parameter int SEQ_W  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LR_W  = 3 * LREG_W,
  localparam int PR_W  = 3 * PREG_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lriqStrobe_t           strb,
  input  logic [IDX_W-1:0]      allocIdx,
  input  logic [TAG_W-1:0]      allocTag,
  input  logic [LR_W-1:0]       allocLregs,
  input  logic [PR_W-1:0]       allocPhys,
  input  logic [SEQ_W-1:0]      allocSeq,
  input  logic                  issueValid,
  input  logic [IDX_W-1:0]      issueIdx,
  input  logic [IDX_W-1:0]      sendBase,
  input  logic [LANES-1:0]      sendMask,
  input  logic                  retValid,
  input  logic [IDX_W-1:0]      retIdx,
  input  logic [LANES-1:0]      retMask,
  input  logic [LANES*PR_W-1:0] retPhys,
  input  logic [SEQ_W-1:0]      flushSeq,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic [DEPTH-1:0]      validVec,
  output logic [DEPTH-1:0]      issuedVec,
  output logic [LANES*LR_W-1:0] laneLregs,
  output logic                  rdValid,
  output logic                  rdClass,
  output logic                  rdIssued,
  output logic [TAG_W-1:0]      rdTag,
  output logic [LR_W-1:0]       rdLregs,
  output logic [PR_W-1:0]       rdPhys
);

  logic [DEPTH-1:0] classVec;
  logic [TAG_W-1:0] tagMem  [DEPTH];
  logic [LR_W-1:0]  lregMem [DEPTH];
  logic [PR_W-1:0]  physMem [DEPTH];
  logic [SEQ_W-1:0] seqMem  [DEPTH];
  logic [DEPTH-1:0] younger;
  logic [DEPTH-1:0] sendHit;
  logic [DEPTH-1:0] retHit;
  logic [PR_W-1:0]  retFor  [DEPTH];

  // per-entry decode of age, send lanes and rename-return lanes
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [SEQ_W-1:0] ageDiff;
    assign ageDiff    = seqMem[e] - flushSeq;
    assign younger[e] = (ageDiff != '0) && !ageDiff[SEQ_W-1];

    always_comb begin
      sendHit[e] = 1'b0;
      retHit[e]  = 1'b0;
      retFor[e]  = '0;
      for (int k = 0; k < LANES; k++) begin
        if (strb.sendEn && sendMask[k] && IDX_W'(sendBase + IDX_W'(k)) == IDX_W'(e))
          sendHit[e] = 1'b1;
        if (retValid && retMask[k] && IDX_W'(retIdx + IDX_W'(k)) == IDX_W'(e)) begin
          retHit[e] = 1'b1;
          retFor[e] = retPhys[k*PR_W +: PR_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec  <= '0;
      classVec  <= '0;
      issuedVec <= '0;
    end else if (strb.cleanEn) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (classVec[e] && issuedVec[e])      validVec[e] <= 1'b0;
        else if (strb.flushEn && younger[e])  validVec[e] <= 1'b0;
        classVec[e] <= 1'b0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (sendHit[e]) issuedVec[e] <= 1'b0;
        if (issueValid && issueIdx == IDX_W'(e) && validVec[e]) begin
          if (classVec[e]) issuedVec[e] <= 1'b1;
          else             validVec[e]  <= 1'b0;
        end
      end
      if (strb.allocEn) begin
        validVec[allocIdx]  <= 1'b1;
        classVec[allocIdx]  <= strb.allocClass;
        issuedVec[allocIdx] <= 1'b0;
      end
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (retHit[e] && !strb.cleanEn) physMem[e] <= retFor[e];
    end
    if (strb.allocEn) begin
      tagMem[allocIdx]  <= allocTag;
      lregMem[allocIdx] <= allocLregs;
      physMem[allocIdx] <= allocPhys;
      seqMem[allocIdx]  <= allocSeq;
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++)
      laneLregs[k*LR_W +: LR_W] = lregMem[IDX_W'(sendBase + IDX_W'(k))];
  end

  assign rdValid  = validVec[rdIdx];
  assign rdClass  = classVec[rdIdx];
  assign rdIssued = issuedVec[rdIdx];
  assign rdTag    = tagMem[rdIdx];
  assign rdLregs  = lregMem[rdIdx];
  assign rdPhys   = physMem[rdIdx];

endmodule

// File: rtl/loop_replay_iq.sv
module loop_replay_iq
  import lriq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LANES  = 2,
  parameter int TAG_W  = 8,
  parameter int LREG_W = 5,
  parameter int PREG_W = 6,
  parameter int SEQ_W  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LR_W  = 3 * LREG_W,
  localparam int PR_W  = 3 * PREG_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  allocValid,
  input  logic [TAG_W-1:0]      allocTag,
  input  logic [LR_W-1:0]       allocLregs,
  input  logic [PR_W-1:0]       allocPhys,
  input  logic [SEQ_W-1:0]      allocSeq,
  output logic                  allocReady,
  input  logic                  bufStart,
  input  logic                  bufEnd,
  input  logic                  issueValid,
  input  logic [IDX_W-1:0]      issueIdx,
  output logic                  renValid,
  output logic [IDX_W-1:0]      renIdx,
  output logic [LANES-1:0]      renMask,
  output logic [LANES*LR_W-1:0] renLregs,
  input  logic                  retValid,
  input  logic [IDX_W-1:0]      retIdx,
  input  logic [LANES-1:0]      retMask,
  input  logic [LANES*PR_W-1:0] retPhys,
  input  logic                  revoke,
  input  logic                  mispredict,
  input  logic [IDX_W-1:0]      mispredIdx,
  input  logic [SEQ_W-1:0]      mispredSeq,
  output logic                  frontGate,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic                  rdValid,
  output logic                  rdClass,
  output logic                  rdIssued,
  output logic [TAG_W-1:0]      rdTag,
  output logic [LR_W-1:0]       rdLregs,
  output logic [PR_W-1:0]       rdPhys
);

  lriqStrobe_t      strb;
  logic [IDX_W-1:0] tail;
  logic [IDX_W-1:0] ptr;
  logic [LANES-1:0] sendMask;
  logic [DEPTH-1:0] validVec;
  logic [DEPTH-1:0] issuedVec;

  lriq_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .bufStart(bufStart),
    .bufEnd(bufEnd), .revoke(revoke), .mispredict(mispredict),
    .mispredIdx(mispredIdx), .validVec(validVec), .issuedVec(issuedVec),
    .strb(strb), .tail(tail), .ptr(ptr), .sendMask(sendMask),
    .allocReady(allocReady), .frontGate(frontGate)
  );

  lriq_array #(
    .DEPTH(DEPTH), .LANES(LANES), .TAG_W(TAG_W),
    .LREG_W(LREG_W), .PREG_W(PREG_W), .SEQ_W(SEQ_W)
  ) array_i (
    .clk(clk), .rstN(rstN), .strb(strb), .allocIdx(tail),
    .allocTag(allocTag), .allocLregs(allocLregs), .allocPhys(allocPhys),
    .allocSeq(allocSeq), .issueValid(issueValid), .issueIdx(issueIdx),
    .sendBase(ptr), .sendMask(sendMask), .retValid(retValid),
    .retIdx(retIdx), .retMask(retMask), .retPhys(retPhys),
    .flushSeq(mispredSeq), .rdIdx(rdIdx), .validVec(validVec),
    .issuedVec(issuedVec), .laneLregs(renLregs), .rdValid(rdValid),
    .rdClass(rdClass), .rdIssued(rdIssued), .rdTag(rdTag),
    .rdLregs(rdLregs), .rdPhys(rdPhys)
  );

  assign renValid = strb.sendEn;
  assign renIdx   = ptr;
  assign renMask  = sendMask;

endmodule

// File: rtl/lriq_checker.sv
module lriq_checker (
  input logic clk,
  input logic rstN,
  input logic allocReady,
  input logic frontGate,
  input logic renValid,
  input logic bufEnd,
  input logic revoke,
  input logic mispredict
);

  // R10: replay refuses new writes
  assert_gate_blocks_alloc_R10: assert property (@(posedge clk) disable iff (!rstN)
    frontGate |-> !allocReady);

  // R10: replay only begins after the end of capture
  assert_gate_after_bufend_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frontGate) |-> $past(bufEnd));

  // R5: sends happen only in replay mode
  assert_send_in_replay_R5: assert property (@(posedge clk) disable iff (!rstN)
    renValid |-> frontGate);

  // R8: revoke leaves replay
  assert_revoke_ungates_R8: assert property (@(posedge clk) disable iff (!rstN)
    revoke |=> !frontGate);

  // R9: misprediction leaves replay
  assert_mispredict_ungates_R9: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |=> !frontGate);

  // R4: no send in a cleanup cycle
  assert_no_send_on_cleanup_R4: assert property (@(posedge clk) disable iff (!rstN)
    (revoke || mispredict) |-> !renValid);

endmodule

bind loop_replay_iq lriq_checker chk_i (
  .clk(clk), .rstN(rstN), .allocReady(allocReady), .frontGate(frontGate),
  .renValid(renValid), .bufEnd(bufEnd), .revoke(revoke), .mispredict(mispredict)
);

// File: tb/loop_replay_iq_tb_top.sv
module loop_replay_iq_tb_top;

  localparam int DEPTH  = 8;
  localparam int LANES  = 2;
  localparam int TAG_W  = 8;
  localparam int LREG_W = 5;
  localparam int PREG_W = 6;
  localparam int SEQ_W  = 4;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LR_W   = 3 * LREG_W;
  localparam int PR_W   = 3 * PREG_W;

  // captured loop body: {tag, srcA, srcB, dst}
  localparam logic [TAG_W+LR_W-1:0] LOOP_VEC [3] = '{
    {8'hA0, 5'd1, 5'd2, 5'd3},
    {8'hA1, 5'd4, 5'd5, 5'd6},
    {8'hA2, 5'd7, 5'd8, 5'd9}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0;
  logic [TAG_W-1:0] allocTag = '0;
  logic [LR_W-1:0] allocLregs = '0;
  logic [PR_W-1:0] allocPhys = '0;
  logic [SEQ_W-1:0] allocSeq = '0;
  logic allocReady;
  logic bufStart = 1'b0, bufEnd = 1'b0;
  logic issueValid = 1'b0;
  logic [IDX_W-1:0] issueIdx = '0;
  logic renValid;
  logic [IDX_W-1:0] renIdx;
  logic [LANES-1:0] renMask;
  logic [LANES*LR_W-1:0] renLregs;
  logic retValid = 1'b0;
  logic [IDX_W-1:0] retIdx = '0;
  logic [LANES-1:0] retMask = '0;
  logic [LANES*PR_W-1:0] retPhys = '0;
  logic revoke = 1'b0, mispredict = 1'b0;
  logic [IDX_W-1:0] mispredIdx = '0;
  logic [SEQ_W-1:0] mispredSeq = '0;
  logic frontGate;
  logic [IDX_W-1:0] rdIdx = '0;
  logic rdValid, rdClass, rdIssued;
  logic [TAG_W-1:0] rdTag;
  logic [LR_W-1:0] rdLregs;
  logic [PR_W-1:0] rdPhys;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  loop_replay_iq #(
    .DEPTH(DEPTH), .LANES(LANES), .TAG_W(TAG_W),
    .LREG_W(LREG_W), .PREG_W(PREG_W), .SEQ_W(SEQ_W)
  ) dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIn();
    allocValid = 0; bufStart = 0; bufEnd = 0; issueValid = 0;
    retValid = 0; revoke = 0; mispredict = 0;
  endtask

  task automatic alloc(input logic [TAG_W-1:0] t, input logic [LR_W-1:0] l,
                       input logic [SEQ_W-1:0] s);
    allocValid = 1; allocTag = t; allocLregs = l; allocSeq = s; allocPhys = '0;
    tick(); clearIn();
  endtask

  task automatic issue(input int idx);
    issueValid = 1; issueIdx = IDX_W'(idx);
    tick(); clearIn();
  endtask

  task automatic peek(input int idx);
    rdIdx = IDX_W'(idx);
    #1;
  endtask

  function automatic logic [LR_W-1:0] lregsOf(input int i);
    return {LOOP_VEC[i][LREG_W-1:0], LOOP_VEC[i][2*LREG_W-1:LREG_W],
            LOOP_VEC[i][3*LREG_W-1:2*LREG_W]};
  endfunction

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected < 20000 cycles", wd);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rstN = 1;
    tick();
    // R1 reset state
    peek(0);
    check("R1 allocReady", allocReady, 1);
    check("R1 frontGate", frontGate, 0);
    check("R1 renValid", renValid, 0);
    check("R1 entry0 valid", rdValid, 0);

    // R3 unpinned entries leave on issue
    alloc(8'h10, '0, 4'd0);
    alloc(8'h11, '0, 4'd1);
    issue(0);
    peek(0); check("R3 unpinned freed", rdValid, 0);
    peek(1); check("R3 other kept", rdValid, 1);

    // R2 capture three entries from the table
    bufStart = 1; tick(); clearIn();
    for (int i = 0; i < 3; i++) alloc(LOOP_VEC[i][TAG_W+LR_W-1:LR_W], lregsOf(i), SEQ_W'(i+2));
    for (int i = 0; i < 3; i++) begin
      peek(i+2);
      check("R2 valid", rdValid, 1);
      check("R2 pinned", rdClass, 1);
      check("R2 issued clear", rdIssued, 0);
      check("R2 tag", rdTag, LOOP_VEC[i][TAG_W+LR_W-1:LR_W]);
      check("R2 lregs", rdLregs, lregsOf(i));
    end
    bufEnd = 1; tick(); clearIn();
    check("R10 gate", frontGate, 1);
    check("R10 allocReady", allocReady, 0);
    check("R4 stall none issued", renValid, 0);
    alloc(8'h77, '0, 4'd9);
    peek(5); check("R10 alloc ignored", rdValid, 0);

    // R3 pinned entry stays after issue; R4 partial window stalls
    issue(2);
    peek(2);
    check("R3 pinned kept", rdValid, 1);
    check("R3 issued set", rdIssued, 1);
    check("R4 partial stall", renValid, 0);
    issue(3);
    check("R5 send valid", renValid, 1);
    check("R5 send idx", renIdx, 2);
    check("R5 mask", renMask, 2'b11);
    check("R5 lregs", renLregs, {lregsOf(1), lregsOf(0)});
    tick();
    check("R5 pointer advanced", renIdx, 4);
    check("R5 clipped mask", renMask, 2'b01);
    check("R4 hold", renValid, 0);
    peek(2); check("R5 issued cleared", rdIssued, 0);

    // R7 rename return in place
    retValid = 1; retIdx = 2; retMask = 2'b11;
    retPhys = {6'd15, 6'd14, 6'd13, 6'd12, 6'd11, 6'd10};
    tick(); clearIn();
    peek(2); check("R7 phys lane0", rdPhys, {6'd12, 6'd11, 6'd10});
    peek(3); check("R7 phys lane1", rdPhys, {6'd15, 6'd14, 6'd13});

    // R6 wrap
    issue(4);
    check("R5 tail lane send", renValid, 1);
    tick();
    check("R6 wrap to first", renIdx, 2);

    // R9 misprediction at entry 3 (seq 3)
    issue(2);
    mispredict = 1; mispredIdx = 3; mispredSeq = 4'd3;
    tick(); clearIn();
    peek(2); check("R9 pinned issued freed", rdValid, 0);
    peek(3); check("R9 branch kept", rdValid, 1);
    check("R9 unpinned", rdClass, 0);
    peek(4); check("R9 younger freed", rdValid, 0);
    peek(1); check("R9 older kept", rdValid, 1);
    check("R9 gate low", frontGate, 0);
    alloc(8'h44, '0, 4'd5);
    peek(4); check("R9 write slot", rdTag, 8'h44);

    // R8 revoke
    bufStart = 1; tick(); clearIn();
    for (int i = 0; i < 3; i++) alloc(8'h50 + TAG_W'(i), lregsOf(i), SEQ_W'(6+i));
    bufEnd = 1; tick(); clearIn();
    issue(5); issue(6);
    check("R5 second loop send", renIdx, 5);
    tick();
    issue(5);
    revoke = 1; tick(); clearIn();
    peek(5); check("R8 pinned issued freed", rdValid, 0);
    peek(6); check("R8 sent kept", rdValid, 1);
    check("R8 unpinned", rdClass, 0);
    peek(7); check("R8 unissued kept", rdValid, 1);
    check("R8 gate low", frontGate, 0);

    // R10 empty capture
    bufStart = 1; tick(); clearIn();
    bufEnd = 1; tick(); clearIn();
    check("R10 empty capture no gate", frontGate, 0);
    check("R10 empty capture ready", allocReady, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule